// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block turns single-word requests from an on-chip requester into bus cycles for asynchronous SRAM or EEPROM on a shared 16-bit address/data bus. The low 16 address bits and the data share one set of pins. Address bit 16 has its own pin. An address-latch pulse lets an external latch hold the address. The two address bits above the 17-bit offset select one of up to four 128 kB regions. Each region has its own active-low chip select and its own timing word.

Each region's timing word sets five things: the number of address wait cycles, the number of write-strobe wait cycles, an optional extra address-hold cycle, an optional write-hold cycle and an optional bus-turn cycle after reads. It also selects how byte writes reach the memory. Either two byte-lane enables follow the requested byte mask, or address bit 0 is gated with the write strobe so that two 8-bit devices in one region each see their own write strobe. A master enable must be high before any request is accepted. The requester holds `req` until it sees a one-cycle `ack`.

Top module: `xmem_seq`

## Requirements
- R1: After reset and between cycles every chip select is high. During a bus cycle exactly the chip select indexed by `req_addr[18:17]` is low, and it stays low from the latch cycle through the last hold or turn cycle.
- R2: Each bus cycle starts with exactly one cycle of `xm_ale` high. In that cycle `xm_ad_o` carries offset bits 15:0 with `xm_ad_oe` high, and `xm_a_hi` carries offset bit 16.
- R3: While `port_en` is low, no request is accepted: no chip select falls and `ack` stays low. A request held across the enable is served once `port_en` rises.
- R4: Timing word bits 14:12 (value 0 to 7) insert that many cycles between the latch cycle and the strobe. The address stays driven on `xm_ad_o` in those cycles.
- R5: A write strobe lasts 1 + bits 7:4 cycles. A read strobe lasts one cycle, and `rdata` takes `xm_ad_i` from the end of that cycle. The two strobes are never low together.
- R6: Timing word bit 10 adds one more address-driven cycle before the strobe, after the address wait cycles.
- R7: On a write, timing word bit 8 adds one cycle after the write strobe. In that cycle the chip select stays low and the write data stays driven.
- R8: On a read, timing word bit 9 adds one cycle after the read strobe. In that cycle the chip select stays low and the bus is released.
- R9: With timing word bit 15 clear, `xm_ble_n` equals the inverse of `req_be[0]` and `xm_bhe_n` equals the inverse of `req_be[1]` for every cycle of the chip select, on reads and writes alike.
- R10: With timing word bit 15 set, `xm_ble_n` is low only during write-strobe cycles at an even offset, and `xm_bhe_n` only during write-strobe cycles at an odd offset. On reads both stay high.
- R11: On reads, `xm_ad_oe` is low from the read strobe until the chip select rises. On writes it is high for the whole cycle.
- R12: `ack` is high for exactly one cycle. That cycle directly follows the last chip-select cycle, and `rdata` is valid in it.
- R13: A timing word is sampled when its request is accepted. A timing-word write in the same clock as the acceptance applies only to later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_en | input | 1 | Master enable for the external port |
| cfg_we | input | 1 | Write strobe for a region timing word |
| cfg_idx | input | 2 | Region whose timing word is written |
| cfg_wdata | input | 16 | Timing word: [15] byte gating, [14:12] address wait, [10] address hold, [9] bus turn, [8] write hold, [7:4] write wait |
| req | input | 1 | Access request, held until ack |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | [18:17] region, [16:0] offset |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte mask, bit 1 high byte, bit 0 low byte |
| ack | output | 1 | One-cycle completion |
| rdata | output | 16 | Read data |
| xm_ad_o | output | 16 | Multiplexed address/data out |
| xm_ad_oe | output | 1 | Drive enable for the shared bus |
| xm_ad_i | input | 16 | Multiplexed data in |
| xm_a_hi | output | 1 | Offset bit 16 |
| xm_ale | output | 1 | Address latch pulse |
| xm_rd_n | output | 1 | Read strobe, active low |
| xm_wr_n | output | 1 | Write strobe, active low |
| xm_bhe_n | output | 1 | High-byte enable, active low |
| xm_ble_n | output | 1 | Low-byte enable, active low |
| xm_cs_n | output | 4 | Region chip selects, active low |

## Verification
A timing-word write and the acceptance of a request for the same region can land on one clock edge. The bench provokes this by raising `cfg_we` and `req` at the same falling edge, with a new timing word that adds two address wait cycles. It then counts the address-driven cycles between the latch pulse and the strobe. The first cycle must show none. A second request to the same region must show two.

// File: rtl/xmem_pkg.sv
// Shared types for the external memory sequencer.
// Assumes a 16-bit multiplexed bus and the fixed timing word layout below.
package xmem_pkg;
    localparam int AWT_W = 3;   // address wait field width
    localparam int WWT_W = 4;   // write wait field width

    // Sequencer states, in bus order
    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_AWAIT, ST_AHOLD, ST_STRB, ST_WHOLD, ST_TURN, ST_FIN
    } xm_state_e;

    // Meaningful bits of one region timing word
    typedef struct packed {
        logic              lane_gate;  // word bit 15
        logic [AWT_W-1:0]  addr_wait;  // word bits 14:12
        logic              addr_hold;  // word bit 10
        logic              turn;       // word bit 9
        logic              wr_hold;    // word bit 8
        logic [WWT_W-1:0]  wr_wait;    // word bits 7:4
    } xm_cfg_t;
endpackage

// File: rtl/xmem_cfg_bank.sv
// Per-region timing word storage with one write port and one read port.
// Assumes NREG is a power of two of at least 2.
module xmem_cfg_bank
    import xmem_pkg::*;
#(
    parameter int NREG = 4,
    localparam int SW = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_idx,
    input  xm_cfg_t       wr_cfg,
    input  logic [SW-1:0] rd_idx,
    output xm_cfg_t       rd_cfg
);
    xm_cfg_t bank [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        xm_cfg_t r_q;
        // Hold region i timing word; reset to fastest timing, lane mode
        always_ff @(posedge clk) begin
            if (!rst_n)                              r_q <= '0;
            else if (wr_en && wr_idx == SW'(i))      r_q <= wr_cfg;
        end
        assign bank[i] = r_q;
    end

    assign rd_cfg = bank[rd_idx];
endmodule

// File: rtl/xmem_region_dec.sv
// Turns a region index into active-low one-hot chip selects.
// Assumes en is high only while a bus cycle owns the pins.
module xmem_region_dec #(
    parameter int NREG = 4,
    localparam int SW = $clog2(NREG)
) (
    input  logic            en,
    input  logic [SW-1:0]   sel,
    output logic [NREG-1:0] cs_n
);
    for (genvar i = 0; i < NREG; i++) begin : g_cs
        assign cs_n[i] = !(en && sel == SW'(i));
    end
endmodule

// File: rtl/xmem_fsm.sv
// Bus-cycle phase sequencer: latch, address wait, address hold, strobe,
// write hold or bus turn, then finish. Assumes cfg and we stay stable
// from start until the cycle returns to idle.
module xmem_fsm
    import xmem_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      we,
    input  xm_cfg_t   cfg,
    output xm_state_e state
);
    xm_state_e        st_q, st_d;
    logic [WWT_W-1:0] cnt_q, cnt_d;
    logic [WWT_W-1:0] strb_len;
    logic             unused_gate;

    assign unused_gate = cfg.lane_gate;
    assign strb_len    = we ? cfg.wr_wait : '0;

    // Next phase and remaining-cycle count
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_IDLE:  if (start) st_d = ST_ADDR;
            ST_ADDR: begin
                if (cfg.addr_wait != '0) begin
                    st_d  = ST_AWAIT;
                    cnt_d = WWT_W'(cfg.addr_wait) - WWT_W'(1);
                end else if (cfg.addr_hold) begin
                    st_d = ST_AHOLD;
                end else begin
                    st_d  = ST_STRB;
                    cnt_d = strb_len;
                end
            end
            ST_AWAIT: begin
                if (cnt_q == '0) begin
                    if (cfg.addr_hold) st_d = ST_AHOLD;
                    else begin
                        st_d  = ST_STRB;
                        cnt_d = strb_len;
                    end
                end else begin
                    cnt_d = cnt_q - WWT_W'(1);
                end
            end
            ST_AHOLD: begin
                st_d  = ST_STRB;
                cnt_d = strb_len;
            end
            ST_STRB: begin
                if (cnt_q == '0) begin
                    if (we) st_d = cfg.wr_hold ? ST_WHOLD : ST_FIN;
                    else    st_d = cfg.turn    ? ST_TURN  : ST_FIN;
                end else begin
                    cnt_d = cnt_q - WWT_W'(1);
                end
            end
            ST_WHOLD: st_d = ST_FIN;
            ST_TURN:  st_d = ST_FIN;
            ST_FIN:   st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // Phase and counter registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign state = st_q;
endmodule

// File: rtl/xmem_pins.sv
// Drives the external bus pins from the current phase and the accepted
// request. Assumes the request fields are held for the whole bus cycle.
module xmem_pins
    import xmem_pkg::*;
#(
    parameter int DW = 16,
    localparam int OFF_W = DW + 1
) (
    input  xm_state_e        state,
    input  logic             we,
    input  logic [OFF_W-1:0] off,
    input  logic [DW-1:0]    wdata,
    input  logic [1:0]       be,
    input  logic             lane_gate,
    output logic             cs_en,
    output logic [DW-1:0]    ad_o,
    output logic             ad_oe,
    output logic             a_hi,
    output logic             ale,
    output logic             rd_n,
    output logic             wr_n,
    output logic             bhe_n,
    output logic             ble_n
);
    logic addr_ph, data_ph, rd_act, wr_act;

    // Phase decode for bus direction and strobes
    always_comb begin
        addr_ph = state inside {ST_ADDR, ST_AWAIT, ST_AHOLD};
        data_ph = we && (state inside {ST_STRB, ST_WHOLD});
        cs_en   = addr_ph || (state inside {ST_STRB, ST_WHOLD, ST_TURN});
        rd_act  = (state == ST_STRB) && !we;
        wr_act  = (state == ST_STRB) && we;
    end

    // Shared bus contents and high address pin
    always_comb begin
        ad_oe = addr_ph || data_ph;
        if (addr_ph)      ad_o = off[DW-1:0];
        else if (data_ph) ad_o = wdata;
        else              ad_o = '0;
        a_hi  = cs_en && off[DW];
        ale   = (state == ST_ADDR);
        rd_n  = !rd_act;
        wr_n  = !wr_act;
    end

    // Byte enables: gated by offset bit 0 or following the byte mask
    always_comb begin
        if (lane_gate) begin
            ble_n = !(wr_act && !off[0]);
            bhe_n = !(wr_act &&  off[0]);
        end else begin
            ble_n = !(cs_en && be[0]);
            bhe_n = !(cs_en && be[1]);
        end
    end
endmodule

// File: rtl/xmem_seq.sv
// Top of the external memory sequencer: accepts one request at a time,
// snapshots the region timing word, and runs one bus cycle per request.
// Assumes req and its fields are held until ack.
module xmem_seq
    import xmem_pkg::*;
#(
    parameter int NREG = 4,
    parameter int DW   = 16,
    localparam int SW    = $clog2(NREG),
    localparam int OFF_W = DW + 1,
    localparam int AW    = OFF_W + SW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            port_en,
    input  logic            cfg_we,
    input  logic [SW-1:0]   cfg_idx,
    input  logic [15:0]     cfg_wdata,
    input  logic            req,
    input  logic            req_we,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_wdata,
    input  logic [1:0]      req_be,
    output logic            ack,
    output logic [DW-1:0]   rdata,
    output logic [DW-1:0]   xm_ad_o,
    output logic            xm_ad_oe,
    input  logic [DW-1:0]   xm_ad_i,
    output logic            xm_a_hi,
    output logic            xm_ale,
    output logic            xm_rd_n,
    output logic            xm_wr_n,
    output logic            xm_bhe_n,
    output logic            xm_ble_n,
    output logic [NREG-1:0] xm_cs_n
);
    xm_cfg_t          wr_cfg, cur_cfg, t_cfg;
    xm_state_e        state;
    logic             accept, cs_en;
    logic             t_we;
    logic [AW-1:0]    t_addr;
    logic [DW-1:0]    t_wdata;
    logic [1:0]       t_be;
    logic             unused_cfg_bits;

    // Timing word fields taken from their fixed bit positions
    assign wr_cfg = '{lane_gate: cfg_wdata[15], addr_wait: cfg_wdata[14:12],
                      addr_hold: cfg_wdata[10], turn: cfg_wdata[9],
                      wr_hold: cfg_wdata[8], wr_wait: cfg_wdata[7:4]};
    assign unused_cfg_bits = ^{cfg_wdata[11], cfg_wdata[3:0]};

    xmem_cfg_bank #(.NREG(NREG)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_we),
        .wr_idx (cfg_idx),
        .wr_cfg (wr_cfg),
        .rd_idx (req_addr[AW-1:OFF_W]),
        .rd_cfg (cur_cfg)
    );

    assign accept = (state == ST_IDLE) && req && port_en;

    // Snapshot request and region timing at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_we    <= 1'b0;
            t_addr  <= '0;
            t_wdata <= '0;
            t_be    <= '0;
            t_cfg   <= '0;
        end else if (accept) begin
            t_we    <= req_we;
            t_addr  <= req_addr;
            t_wdata <= req_wdata;
            t_be    <= req_be;
            t_cfg   <= cur_cfg;
        end
    end

    xmem_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept),
        .we    (t_we),
        .cfg   (t_cfg),
        .state (state)
    );

    xmem_pins #(.DW(DW)) u_pins (
        .state     (state),
        .we        (t_we),
        .off       (t_addr[OFF_W-1:0]),
        .wdata     (t_wdata),
        .be        (t_be),
        .lane_gate (t_cfg.lane_gate),
        .cs_en     (cs_en),
        .ad_o      (xm_ad_o),
        .ad_oe     (xm_ad_oe),
        .a_hi      (xm_a_hi),
        .ale       (xm_ale),
        .rd_n      (xm_rd_n),
        .wr_n      (xm_wr_n),
        .bhe_n     (xm_bhe_n),
        .ble_n     (xm_ble_n)
    );

    xmem_region_dec #(.NREG(NREG)) u_dec (
        .en   (cs_en),
        .sel  (t_addr[AW-1:OFF_W]),
        .cs_n (xm_cs_n)
    );

    // Capture read data at the end of the read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)                               rdata <= '0;
        else if (state == ST_STRB && !t_we)       rdata <= xm_ad_i;
    end

    assign ack = (state == ST_FIN);
endmodule

// File: rtl/xmem_seq_chk.sv
// Protocol checker for the external memory sequencer, bound to xmem_seq.
// Assumes only the top-level ports are visible.
module xmem_seq_chk #(
    parameter int NREG = 4,
    parameter int DW   = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            port_en,
    input logic            ack,
    input logic [DW-1:0]   xm_ad_o,
    input logic            xm_ad_oe,
    input logic            xm_ale,
    input logic            xm_rd_n,
    input logic            xm_wr_n,
    input logic [NREG-1:0] xm_cs_n
);
    p_one_cs_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~xm_cs_n) <= 1);

    p_ale_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        xm_ale |=> !xm_ale);

    p_ale_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        xm_ale |-> (xm_ad_oe && $countones(~xm_cs_n) == 1));

    p_idle_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!port_en && (&xm_cs_n)) |=> (&xm_cs_n));

    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!xm_rd_n && !xm_wr_n));

    p_rd_float_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !xm_rd_n |-> !xm_ad_oe);

    p_wr_drive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !xm_wr_n |-> xm_ad_oe);

    p_ack_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    p_ack_desel_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> ((&xm_cs_n) && xm_rd_n && xm_wr_n));

    logic unused_ad;
    assign unused_ad = ^xm_ad_o;
endmodule

bind xmem_seq xmem_seq_chk #(.NREG(NREG), .DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .port_en  (port_en),
    .ack      (ack),
    .xm_ad_o  (xm_ad_o),
    .xm_ad_oe (xm_ad_oe),
    .xm_ale   (xm_ale),
    .xm_rd_n  (xm_rd_n),
    .xm_wr_n  (xm_wr_n),
    .xm_cs_n  (xm_cs_n)
);

// File: tb/tb_xmem_seq.sv
// Self-checking bench for xmem_seq: a vector table of bus cycles, then
// directed reset, enable and timing-word collision tests.
module tb_xmem_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        port_en = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic [15:0] cfg_wdata = '0;
    logic        req = 1'b0;
    logic        req_we = 1'b0;
    logic [18:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        ack;
    logic [15:0] rdata, xm_ad_o, xm_ad_i;
    logic        xm_ad_oe, xm_a_hi, xm_ale, xm_rd_n, xm_wr_n, xm_bhe_n, xm_ble_n;
    logic [3:0]  xm_cs_n;

    int n_run = 0, n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    xmem_seq dut (.*);

    // External memory model: 64 words, indexed by region and offset bits 4:1
    logic [15:0] mem [64];
    logic [5:0]  m_idx = '0;
    function automatic logic [1:0] cs_num(input logic [3:0] c);
        for (int i = 0; i < 4; i++) if (!c[i]) return 2'(i);
        return 2'd0;
    endfunction
    initial for (int i = 0; i < 64; i++) mem[i] = '0;
    assign xm_ad_i = !xm_rd_n ? mem[m_idx] : 16'hFFFF;
    always @(negedge clk) begin
        if (xm_ale) m_idx <= {cs_num(xm_cs_n), xm_ad_o[4:1]};
        if (!xm_wr_n && !xm_ble_n) mem[m_idx][7:0]  <= xm_ad_o[7:0];
        if (!xm_wr_n && !xm_bhe_n) mem[m_idx][15:8] <= xm_ad_o[15:8];
    end

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Observed per-cycle counts
    int cs_cnt, cs_bad, ale_cnt, ale_addr, pre_cnt, pre_bad, wr_cnt, rd_cnt;
    int post_cnt, float_cnt, ble_cnt, bhe_cnt, ack_seen;

    task automatic wait_done(input logic [1:0] rg, input logic [16:0] off);
        bit seen = 0;
        cs_cnt = 0; cs_bad = 0; ale_cnt = 0; ale_addr = 0; pre_cnt = 0; pre_bad = 0;
        wr_cnt = 0; rd_cnt = 0; post_cnt = 0; float_cnt = 0; ble_cnt = 0; bhe_cnt = 0;
        ack_seen = 0;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            cfg_we = 1'b0;
            if (ack) begin ack_seen = 1; break; end
            if (xm_cs_n != 4'hF) begin
                cs_cnt++;
                if (xm_cs_n != ~(4'b1 << rg)) cs_bad++;
                if (!xm_ad_oe) float_cnt++;
                if (!xm_ble_n) ble_cnt++;
                if (!xm_bhe_n) bhe_cnt++;
            end
            if (xm_ale) begin
                ale_cnt++;
                ale_addr = {15'd0, xm_a_hi, xm_ad_o};
            end
            if (!xm_rd_n || !xm_wr_n) begin
                seen = 1;
                if (!xm_wr_n) wr_cnt++;
                if (!xm_rd_n) rd_cnt++;
            end else if (xm_cs_n != 4'hF && !xm_ale) begin
                if (!seen) begin
                    pre_cnt++;
                    if (!xm_ad_oe || xm_ad_o != off[15:0]) pre_bad++;
                end else post_cnt++;
            end
        end
        check("R12 ack arrives", ack_seen, 1);
        check("R12 chip select released in ack cycle", int'(xm_cs_n), 15);
        req = 1'b0;
        @(negedge clk);
        check("R12 ack lasts one cycle", int'(ack), 0);
    endtask

    task automatic set_cfg(input logic [1:0] rg, input logic [15:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = rg; cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic drive_req(input logic [1:0] rg, input logic we,
                             input logic [16:0] off, input logic [15:0] wd,
                             input logic [1:0] be);
        req = 1'b1; req_we = we; req_addr = {rg, off}; req_wdata = wd; req_be = be;
    endtask

    // Vector table: region, timing word, write, offset, write data, byte mask, expected read
    typedef struct packed {
        logic [1:0]  rg;
        logic [15:0] cfg;
        logic        we;
        logic [16:0] off;
        logic [15:0] wd;
        logic [1:0]  be;
        logic [15:0] exp;
    } vec_t;
    localparam vec_t VEC [10] = '{
        '{2'd0, 16'h0000, 1'b1, 17'h00010, 16'h1234, 2'b11, 16'h0000},
        '{2'd0, 16'h0000, 1'b0, 17'h00010, 16'h0000, 2'b11, 16'h1234},
        '{2'd1, 16'h3050, 1'b1, 17'h00004, 16'hABCD, 2'b01, 16'h0000},
        '{2'd1, 16'h3750, 1'b0, 17'h00004, 16'h0000, 2'b11, 16'h00CD},
        '{2'd2, 16'h0120, 1'b1, 17'h1FFFE, 16'h5A5A, 2'b10, 16'h0000},
        '{2'd2, 16'h7200, 1'b0, 17'h1FFFE, 16'h0000, 2'b11, 16'h5A00},
        '{2'd3, 16'h8010, 1'b1, 17'h00009, 16'h7700, 2'b00, 16'h0000},
        '{2'd3, 16'h8010, 1'b1, 17'h00008, 16'h0033, 2'b00, 16'h0000},
        '{2'd3, 16'h8000, 1'b0, 17'h00008, 16'h0000, 2'b00, 16'h7733},
        '{2'd3, 16'h0600, 1'b0, 17'h00009, 16'h0000, 2'b11, 16'h7733}
    };

    task automatic judge(input vec_t v);
        int aw = int'(v.cfg[14:12]);
        int ah = int'(v.cfg[10]);
        int ws = int'(v.cfg[7:4]);
        int s  = v.we ? 1 + ws : 1;
        int h  = v.we ? int'(v.cfg[8]) : int'(v.cfg[9]);
        int cs = 1 + aw + ah + s + h;
        check("R1 chip select width", cs_cnt, cs);
        check("R1 only the decoded region selected", cs_bad, 0);
        check("R2 one latch pulse", ale_cnt, 1);
        check("R2 latched address", ale_addr, int'(v.off));
        check("R4 R6 address cycles before strobe", pre_cnt, aw + ah);
        check("R4 R6 address held on bus", pre_bad, 0);
        check("R5 write strobe length", wr_cnt, v.we ? 1 + ws : 0);
        check("R5 read strobe length", rd_cnt, v.we ? 0 : 1);
        check("R7 R8 hold or turn cycles", post_cnt, h);
        check("R11 bus released cycles", float_cnt, v.we ? 0 : 1 + h);
        if (v.cfg[15]) begin
            check("R10 gated low byte", ble_cnt, (v.we && !v.off[0]) ? 1 + ws : 0);
            check("R10 gated high byte", bhe_cnt, (v.we && v.off[0]) ? 1 + ws : 0);
        end else begin
            check("R9 low byte enable", ble_cnt, v.be[0] ? cs : 0);
            check("R9 high byte enable", bhe_cnt, v.be[1] ? cs : 0);
        end
        if (!v.we) check("R5 R12 read data", int'(rdata), int'(v.exp));
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL R12 watchdog expired actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // Reset state
        repeat (3) @(negedge clk);
        check("R1 reset chip selects high", int'(xm_cs_n), 15);
        check("R2 reset no latch pulse", int'(xm_ale), 0);
        check("R5 reset strobes idle", int'({xm_rd_n, xm_wr_n}), 3);
        check("R12 reset ack low", int'(ack), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: request held while the port is disabled
        drive_req(2'd0, 1'b0, 17'h00010, 16'h0, 2'b11);
        begin
            int act = 0;
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                if (xm_cs_n != 4'hF || ack) act++;
            end
            check("R3 no activity while disabled", act, 0);
        end
        port_en = 1'b1;
        wait_done(2'd0, 17'h00010);
        check("R3 served after enable", ale_cnt, 1);

        // Vector table
        for (int i = 0; i < 10; i++) begin
            set_cfg(VEC[i].rg, VEC[i].cfg);
            drive_req(VEC[i].rg, VEC[i].we, VEC[i].off, VEC[i].wd, VEC[i].be);
            wait_done(VEC[i].rg, VEC[i].off);
            judge(VEC[i]);
        end

        // R13: timing-word write in the acceptance clock
        set_cfg(2'd0, 16'h0000);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 2'd0; cfg_wdata = 16'h2000;
        drive_req(2'd0, 1'b0, 17'h00010, 16'h0, 2'b11);
        wait_done(2'd0, 17'h00010);
        check("R13 old timing used in collision cycle", pre_cnt, 0);
        drive_req(2'd0, 1'b0, 17'h00010, 16'h0, 2'b11);
        wait_done(2'd0, 17'h00010);
        check("R13 new timing used next cycle", pre_cnt, 2);
        check("R13 read data", int'(rdata), 16'h1234);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule